// File: doc/BRIEF.md
# Write-Only Serial Configuration Port

This block is a serial slave that lets an external controller load a small bank of 8-bit configuration registers over three wires: an active-low frame select, a serial clock and a serial data line. Each transfer is one 16-bit word, most significant bit first. The top bit is a direction flag that must be zero. The next seven bits give the register address, and the low eight bits give the value. There is no read path and no data output pin.

All three serial lines, and the two mode-select pins, are sampled by a faster system clock. Each line goes through a two-flop synchronizer, and edges are found in the system domain. The port only responds when both mode-select pins are high. A word is committed when the frame select returns high, and only if exactly sixteen serial clock rising edges arrived while the frame was open. On commit the block issues a one-cycle write strobe with the address and data, and it updates the matching register if that address is implemented.

The system clock must run at least eight times faster than the serial clock. The serial clock must be low when the frame select falls. Between words, the frame select must stay high for at least two serial clock periods.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, every register in the bank reads zero and the write strobe is low.
- R2: When the two mode-select pins are not both high, serial traffic produces no strobe and changes no register.
- R3: A word is shifted in most significant bit first, one bit per rising serial clock edge while the frame select is low. Bit 15 is the direction flag, bits 14..8 are the address with bit 14 as MSB, and bits 7..0 are the data with bit 7 as MSB.
- R4: When the frame select rises after a valid frame, the write strobe is high for exactly one system clock cycle, with the received address and data on the write outputs.
- R5: A word whose bit 15 is 1 is discarded: no strobe and no register change.
- R6: A frame that ends with a bit count other than 16 (for example 15 or 17) is discarded.
- R7: A frame whose frame select falls while the serial clock is high is not accepted, even if 16 bits follow.
- R8: Serial clock and data transitions while the frame select is high have no effect on the strobe or on the registers.
- R9: A committed word writes the register at its address when the address is below NUM_REGS. A committed word with a higher address still strobes but changes no register.
- R10: The strobe appears on the third system clock rising edge after the frame select input rises. The register takes the new value one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode-select pins; port active when both are 1 |
| ser_sel_ni | input | 1 | Active-low frame select |
| ser_clk_i | input | 1 | Serial clock; data captured on its rising edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| wr_stb_o | output | 1 | One-cycle pulse for each committed word |
| wr_addr_o | output | 7 | Address of the committed word |
| wr_data_o | output | 8 | Data of the committed word |
| regs_o | output | NUM_REGS*8 | Register bank contents, register k in bits 8k+7..8k |

## Verification
A stuck or miscounted bit counter shows up at the frame-select rise. Either a valid word loses its strobe, or a 15- or 17-bit word gets one, and in both cases the problem is visible three system cycles after the rise. A shift register that is not cleared, or that shifts in the wrong direction, gives a strobe whose address or data differs from the word that was sent. A bad register-bank decode shows up on the register outputs one cycle after the strobe, as a wrong register changing or an out-of-range address leaking into the bank. Errors in the arming logic (the mode pins, or the clock level when the frame opens) show as strobes on frames that should have been rejected.

// File: rtl/cfgport_pkg.sv
`timescale 1ns/1ps
package cfgport_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int CNT_MAX    = FRAME_BITS + 1;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shift;
        logic [CNT_W-1:0]      cnt;
        logic                  armed;
        logic                  sel_p;
        logic                  clk_p;
        logic                  stb;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     data;
    } rx_state_t;
endpackage

// File: rtl/cfgport_sync.sv
`timescale 1ns/1ps
module cfgport_sync #(
    parameter int          WIDTH   = 5,
    parameter logic [31:0] RST_VAL = 32'h0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    // Two flops per line; each line gets its own reset level.
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic meta_q, stab_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end
        assign sync_o[g] = stab_q;
    end
endmodule

// File: rtl/cfgport_rx.sv
`timescale 1ns/1ps
module cfgport_rx import cfgport_pkg::*; (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              sel_ni,
    input  logic              sclk_i,
    input  logic              sdat_i,
    output logic              stb_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    rx_state_t q, d;
    logic sel_fall, sel_rise, clk_rise;

    assign sel_fall = q.sel_p & ~sel_ni;
    assign sel_rise = ~q.sel_p & sel_ni;
    assign clk_rise = ~q.clk_p & sclk_i;

    always_comb begin
        d       = q;
        d.stb   = 1'b0;
        d.sel_p = sel_ni;
        d.clk_p = sclk_i;
        if (!en_i) begin
            d.armed = 1'b0;
        end else if (sel_fall) begin
            // A new frame always starts from a clean counter and shifter.
            d.shift = '0;
            d.cnt   = '0;
            d.armed = ~sclk_i;
        end else if (sel_rise) begin
            if (q.armed && (q.cnt == CNT_W'(FRAME_BITS)) && !q.shift[FRAME_BITS-1]) begin
                d.stb  = 1'b1;
                d.addr = q.shift[FRAME_BITS-2 -: ADDR_W];
                d.data = q.shift[DATA_W-1:0];
            end
            d.armed = 1'b0;
        end else if (!sel_ni && q.armed && clk_rise) begin
            d.shift = {q.shift[FRAME_BITS-2:0], sdat_i};
            if (q.cnt != CNT_W'(CNT_MAX))
                d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.sel_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign stb_o  = q.stb;
    assign addr_o = q.addr;
    assign data_o = q.data;

    AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.stb |=> !q.stb); // R4
    AST_STB_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.stb |-> $past(en_i)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= CNT_W'(CNT_MAX)); // R6
    AST_DISARM_ON_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_rise && en_i) |=> !q.armed); // R4
    AST_HIGH_CLK_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_fall && sclk_i) |=> !q.armed); // R7
endmodule

// File: rtl/cfgport_regs.sv
`timescale 1ns/1ps
module cfgport_regs import cfgport_pkg::*; #(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          data_i,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    localparam int CMP_W = ADDR_W + 1;

    logic [NUM_REGS*DATA_W-1:0] regs_d, regs_q;
    logic                       out_of_range;

    assign out_of_range = ({1'b0, addr_i} >= CMP_W'(NUM_REGS));

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_i && addr_i == ADDR_W'(i))
                regs_d[i*DATA_W +: DATA_W] = data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    initial AST_BANK_FITS: assert (NUM_REGS >= 1 && NUM_REGS <= (1 << ADDR_W)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(regs_q)); // R9
    AST_OOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && out_of_range) |=> $stable(regs_q)); // R9
endmodule

// File: rtl/cfg_serial_port.sv
`timescale 1ns/1ps
module cfg_serial_port import cfgport_pkg::*; #(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [1:0]                 mode_i,
    input  logic                       ser_sel_ni,
    input  logic                       ser_clk_i,
    input  logic                       ser_dat_i,
    output logic                       wr_stb_o,
    output logic [ADDR_W-1:0]          wr_addr_o,
    output logic [DATA_W-1:0]          wr_data_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    localparam int NLINES = 5;
    // Line order: mode[1], mode[0], select, clock, data. Select idles high.
    localparam logic [31:0] SYNC_RST = 32'h4;

    logic [NLINES-1:0] raw_lines, synced;
    logic              en_s;

    assign raw_lines = {mode_i, ser_sel_ni, ser_clk_i, ser_dat_i};

    cfgport_sync #(.WIDTH(NLINES), .RST_VAL(SYNC_RST)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_lines),
        .sync_o  (synced)
    );

    assign en_s = synced[4] & synced[3];

    cfgport_rx u_rx (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_s),
        .sel_ni (synced[2]),
        .sclk_i (synced[1]),
        .sdat_i (synced[0]),
        .stb_o  (wr_stb_o),
        .addr_o (wr_addr_o),
        .data_o (wr_data_o)
    );

    cfgport_regs #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr_stb_o),
        .addr_i (wr_addr_o),
        .data_i (wr_data_o),
        .regs_o (regs_o)
    );
endmodule

// File: tb/sim_cfg_serial_port.sv
`timescale 1ns/1ps
module sim_cfg_serial_port;
    localparam int NUM_REGS = 8;
    localparam int HALF     = 50;   // system cycles per serial half period (2 MHz)
    localparam int LAT      = 3;    // R10

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          mode = 2'b11;
    logic                sel_n = 1'b1;
    logic                sclk = 1'b0;
    logic                sdat = 1'b0;
    logic                stb;
    logic [6:0]          waddr;
    logic [7:0]          wdata;
    logic [NUM_REGS*8-1:0] regs;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rise_cyc = 0;
    int stb_seen = 0;
    int stb_exp = 0;
    bit done = 1'b0;
    bit prev_stb = 1'b0;
    logic [7:0] model [NUM_REGS];
    logic [14:0] exp_q [$];

    always #2.5 clk = ~clk;

    cfg_serial_port #(.NUM_REGS(NUM_REGS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
        .ser_sel_ni(sel_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .wr_stb_o(stb), .wr_addr_o(waddr), .wr_data_o(wdata), .regs_o(regs)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (stb) begin
                stb_seen++;
                checks++;
                if (prev_stb) begin
                    errors++;
                    $display("FAIL R4: strobe high two cycles, got 1 expected 0");
                end else if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5/R6/R7/R8/R2: unexpected strobe addr=%h data=%h expected none", waddr, wdata);
                end else begin
                    logic [14:0] e;
                    e = exp_q.pop_front();
                    if ({waddr, wdata} !== e) begin
                        errors++;
                        $display("FAIL R3/R4: strobe addr=%h data=%h expected addr=%h data=%h",
                                 waddr, wdata, e[14:8], e[7:0]);
                    end
                    checks++;
                    if (cyc - rise_cyc != LAT) begin
                        errors++;
                        $display("FAIL R10: strobe latency %0d expected %0d", cyc - rise_cyc, LAT);
                    end
                end
            end
            prev_stb = stb;
        end else begin
            prev_stb = 1'b0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one frame of nbits (MSB of the nbits-wide value first).
    task automatic send(input logic [31:0] bits, input int nbits, input bit clk_high_open);
        @(negedge clk);
        if (clk_high_open) begin
            sclk = 1'b1;
            wait_cyc(HALF);
        end
        sel_n = 1'b0;
        wait_cyc(HALF);
        if (clk_high_open) begin
            sclk = 1'b0;
            wait_cyc(HALF);
        end
        for (int i = nbits - 1; i >= 0; i--) begin
            sdat = bits[i];
            wait_cyc(HALF);
            sclk = 1'b1;
            wait_cyc(HALF);
            sclk = 1'b0;
        end
        wait_cyc(HALF);
        sel_n = 1'b1;
        rise_cyc = cyc;
        wait_cyc(4 * HALF);
    endtask

    task automatic expect_word(input logic [6:0] a, input logic [7:0] v);
        exp_q.push_back({a, v});
        stb_exp++;
        if (a < NUM_REGS) model[a] = v;
    endtask

    task automatic check_regs(input string tag);
        checks++;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (regs[i*8 +: 8] !== model[i]) begin
                errors++;
                $display("FAIL %s: reg %0d got %h expected %h", tag, i, regs[i*8 +: 8], model[i]);
                break;
            end
        end
    endtask

    task automatic check_count(input string tag);
        checks++;
        if (stb_seen != stb_exp) begin
            errors++;
            $display("FAIL %s: strobe count %0d expected %0d", tag, stb_seen, stb_exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NUM_REGS; i++) model[i] = 8'h00;
        wait_cyc(5);
        // R1: reset state
        checks++;
        if (stb !== 1'b0 || regs !== '0) begin
            errors++;
            $display("FAIL R1: stb=%b regs=%h expected 0 and 0", stb, regs);
        end
        rst_n = 1'b1;
        wait_cyc(5);

        // R3 R4 R9: plain writes with varied patterns
        expect_word(7'd0, 8'hA5); send({16'h0000 | (32'd0 << 8) | 32'hA5}, 16, 1'b0);
        expect_word(7'd7, 8'h3C); send({16'h0, 1'b0, 7'd7, 8'h3C}, 16, 1'b0);
        expect_word(7'd3, 8'hFF); send({16'h0, 1'b0, 7'd3, 8'hFF}, 16, 1'b0);
        expect_word(7'd5, 8'h01); send({16'h0, 1'b0, 7'd5, 8'h01}, 16, 1'b0);
        check_regs("R3/R9 writes");
        check_count("R4 writes");
        expect_word(7'd0, 8'h5A); send({16'h0, 1'b0, 7'd0, 8'h5A}, 16, 1'b0);
        check_regs("R9 overwrite");

        // R9: out-of-range addresses strobe but leave the bank alone
        expect_word(7'h40, 8'h77); send({16'h0, 1'b0, 7'h40, 8'h77}, 16, 1'b0);
        expect_word(7'd8, 8'h99);  send({16'h0, 1'b0, 7'd8, 8'h99}, 16, 1'b0);
        check_regs("R9 out of range");
        check_count("R9 strobe");

        // R5: direction flag set
        send({16'h0, 1'b1, 7'd2, 8'hEE}, 16, 1'b0);
        check_count("R5 flag");
        check_regs("R5 flag");

        // R6: short and long frames
        send({17'h0, 1'b0, 7'd2, 7'h11}, 15, 1'b0);
        check_count("R6 15 bits");
        send({15'h0, 1'b0, 7'd2, 8'h22, 1'b1}, 17, 1'b0);
        check_count("R6 17 bits");
        check_regs("R6 bank");

        // R7: clock high when the frame opens
        send({16'h0, 1'b0, 7'd4, 8'h44}, 16, 1'b1);
        check_count("R7 clk high");
        check_regs("R7 bank");

        // R2: mode pins not both high
        mode = 2'b01; wait_cyc(10);
        send({16'h0, 1'b0, 7'd6, 8'h66}, 16, 1'b0);
        mode = 2'b10; wait_cyc(10);
        send({16'h0, 1'b0, 7'd6, 8'h67}, 16, 1'b0);
        check_count("R2 disabled");
        check_regs("R2 bank");
        mode = 2'b11; wait_cyc(10);

        // R8: activity while select is high
        for (int k = 0; k < 20; k++) begin
            sdat = k[0];
            wait_cyc(HALF);
            sclk = ~sclk;
        end
        sclk = 1'b0;
        wait_cyc(2 * HALF);
        check_count("R8 idle toggles");
        check_regs("R8 bank");
        expect_word(7'd6, 8'hC3); send({16'h0, 1'b0, 7'd6, 8'hC3}, 16, 1'b0);
        check_regs("R8 next frame");
        check_count("R8 next frame");

        // R1: reset clears the bank
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        for (int i = 0; i < NUM_REGS; i++) model[i] = 8'h00;
        check_regs("R1 reset");
        checks++;
        if (stb !== 1'b0) begin
            errors++;
            $display("FAIL R1: stb=%b expected 0", stb);
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4: %0d words not seen expected 0", exp_q.size());
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end
endmodule